// File: doc/BRIEF.md
# Zero-Cross Synchronized Stereo Gain Updater

This block holds the volume codes of a stereo gain stage and applies a requested change to them without clicks. A change of N steps, downwards to attenuate or upwards to recover, is latched as one request. Each channel then takes its change at its own zero crossing: the first sample whose sign differs from that channel's previous sample, or a sample that is exactly zero. If a channel sees no crossing, a shared timeout forces the update. The timeout is a count of sample strobes since the request was latched.

Two bypass modes skip the wait. In these modes every pending channel moves by exactly one code step on the next sample strobe, whatever step count was requested. The first mode applies when zero-cross detection is switched off. The second applies when the full-scale-immediate flag is set and the over-full-scale indication is active. Level detection and the decision to attenuate or recover belong to the logic around this block. A single-cycle done pulse tells that logic when both channels have taken the change.

Top module: `zcg_gain_updater`

## Requirements
- R1: After synchronous reset both volume codes equal the parameter VOL_INIT (default 128), done is 0 and no request is pending.
- R2: `tmo_sel` values 0, 1, 2 and 3 select timeouts of 128, 256, 512 and 1024 sample strobes. A pending channel that sees no crossing is updated on the strobe whose count since the latch reaches that number. The same timeout serves both directions. A crossing that falls on the expiry strobe causes only one update.
- R3: With zero-cross detection on, a pending channel is updated on the first strobe where the sign bit of its sample differs from the sign bit of its previous strobed sample, or where its sample is zero. Each channel is judged on its own samples alone.
- R4: With `zc_off`=1, every pending channel changes by exactly one code on the next strobe, regardless of `req_step`.
- R5: With `fs_imm`=1 and `over_fs`=1 on a strobe, every pending channel changes by exactly one code on that strobe. With `fs_imm`=1 and `over_fs`=0, the rules of R2 and R3 apply.
- R6: `req_up`=0 lowers a code by `req_step` and `req_up`=1 raises it by `req_step`, where `req_step` is an unsigned 4-bit step count. A step of zero still completes the request.
- R7: A code saturates at 0 when lowered and at 255 when raised. It never wraps.
- R8: `done` is high for exactly one cycle. That cycle follows the strobe on which the last pending channel was updated, and in it the new codes are already visible.
- R9: A request is latched only when no request is pending. A request that arrives while one is pending has no effect. A strobe in the latch cycle only records sample history and updates no code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample period |
| smp_l | input | 16 | Signed left sample |
| smp_r | input | 16 | Signed right sample |
| req_vld | input | 1 | Gain-change request |
| req_up | input | 1 | Direction: 0 lowers, 1 raises |
| req_step | input | 4 | Number of code steps |
| tmo_sel | input | 2 | Timeout select |
| zc_off | input | 1 | Zero-cross detection disabled |
| fs_imm | input | 1 | Full-scale-immediate mode |
| over_fs | input | 1 | Output at or above full scale |
| vol_l | output | 8 | Left volume code |
| vol_r | output | 8 | Right volume code |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same sample strobe: a channel's zero crossing and the timeout expiry. Either one alone would move the channel by the full step. The bench provokes this by making the left sample change sign on exactly the 128th strobe after a latch, while the right sample stays positive. It then judges that the left code moved by the requested step once and not twice, that the right code moved by the same step through the timeout, and that done rose a single time. A second collision is also driven: a request and a strobe in the same cycle. The bench checks that the strobe is taken as history only.

// File: rtl/zcg_pkg.sv
package zcg_pkg;

    localparam int TMO_SEL_W = 2;
    localparam int TMO_BASE  = 128;
    localparam int TMO_CNT_W = 11;
    localparam int NUM_CH    = 2;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_ZC   = 2'd1,
        UPD_TMO  = 2'd2,
        UPD_IMM  = 2'd3
    } upd_cause_e;

    typedef struct packed {
        logic                 busy;
        logic [NUM_CH-1:0]    pend;
        logic                 up;
    } ctl_state_t;

    function automatic logic [TMO_CNT_W-1:0] tmo_limit(input logic [TMO_SEL_W-1:0] sel);
        logic [TMO_CNT_W-1:0] base;
        base = TMO_CNT_W'(TMO_BASE);
        return base << sel;
    endfunction

    function automatic upd_cause_e pick_cause(input logic imm, input logic expire, input logic zc);
        if (imm)         return UPD_IMM;
        else if (expire) return UPD_TMO;
        else if (zc)     return UPD_ZC;
        else             return UPD_NONE;
    endfunction

endpackage

// File: rtl/zcg_zc_det.sv
module zcg_zc_det #(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] smp,
    output logic                       zc
);
    localparam int MSB = SAMPLE_W - 1;

    logic prev_neg;

    always_ff @(posedge clk) begin
        if (rst)          prev_neg <= 1'b0;
        else if (smp_vld) prev_neg <= smp[MSB];
    end

    always_comb begin
        zc = (smp[MSB] != prev_neg) || (smp == '0);
    end
endmodule

// File: rtl/zcg_tmo_cnt.sv
module zcg_tmo_cnt
    import zcg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 busy,
    input  logic                 smp_vld,
    input  logic [TMO_SEL_W-1:0] sel,
    output logic                 expire
);
    logic [TMO_CNT_W-1:0] cnt;
    logic [TMO_CNT_W-1:0] cnt_nxt;
    logic [TMO_CNT_W-1:0] lim;

    always_comb begin
        lim     = tmo_limit(sel);
        cnt_nxt = cnt + TMO_CNT_W'(1);
        expire  = busy && smp_vld && (cnt_nxt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst || start)          cnt <= '0;
        else if (busy && smp_vld && !expire) cnt <= cnt_nxt;
    end

    AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (rst)
        cnt < tmo_limit(2'b11)) else $error("count beyond longest timeout"); // R2
endmodule

// File: rtl/zcg_chan_vol.sv
module zcg_chan_vol #(
    parameter int          VOL_W    = 8,
    parameter int          STEP_W   = 4,
    parameter logic [VOL_W-1:0] VOL_INIT = 8'd128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              imm,
    input  logic              up,
    input  logic [STEP_W-1:0] step,
    output logic [VOL_W-1:0]  vol
);
    localparam logic [VOL_W-1:0] VOL_MAX = {VOL_W{1'b1}};

    logic [VOL_W-1:0] amt;
    logic [VOL_W:0]   sum;
    logic [VOL_W-1:0] vol_nxt;

    always_comb begin
        amt = imm ? VOL_W'(1) : VOL_W'(step);
        sum = {1'b0, vol} + {1'b0, amt};
        if (up) vol_nxt = (sum > {1'b0, VOL_MAX}) ? VOL_MAX : sum[VOL_W-1:0];
        else    vol_nxt = (vol >= amt) ? (vol - amt) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)      vol <= VOL_INIT;
        else if (upd) vol <= vol_nxt;
    end

    AST_DOWN_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (upd && !up) |=> (vol <= $past(vol))) else $error("down wrap"); // R7
    AST_UP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (upd && up) |=> (vol >= $past(vol))) else $error("up wrap"); // R7
    AST_IMM_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (upd && imm) |=> ((vol == $past(vol)) || (vol == $past(vol) + VOL_W'(1))
                          || (vol == $past(vol) - VOL_W'(1)))) else $error("imm step"); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(vol)) else $error("idle change"); // R9
endmodule

// File: rtl/zcg_gain_updater.sv
module zcg_gain_updater
    import zcg_pkg::*;
#(
    parameter int               SAMPLE_W = 16,
    parameter int               VOL_W    = 8,
    parameter int               STEP_W   = 4,
    parameter logic [VOL_W-1:0] VOL_INIT = 8'd128
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] smp_l,
    input  logic signed [SAMPLE_W-1:0] smp_r,
    input  logic                       req_vld,
    input  logic                       req_up,
    input  logic [STEP_W-1:0]          req_step,
    input  logic [TMO_SEL_W-1:0]       tmo_sel,
    input  logic                       zc_off,
    input  logic                       fs_imm,
    input  logic                       over_fs,
    output logic [VOL_W-1:0]           vol_l,
    output logic [VOL_W-1:0]           vol_r,
    output logic                       done
);
    ctl_state_t          st;
    logic [STEP_W-1:0]   step_q;
    logic                latch;
    logic                act;
    logic                imm_mode;
    logic                tmo_exp;
    logic [NUM_CH-1:0]   zc;
    logic [NUM_CH-1:0]   fire;
    logic [NUM_CH-1:0]   pend_left;
    upd_cause_e          cause [NUM_CH];
    logic signed [SAMPLE_W-1:0] smp_a [NUM_CH];
    logic [VOL_W-1:0]    vol_a [NUM_CH];

    assign smp_a[0] = smp_l;
    assign smp_a[1] = smp_r;
    assign vol_l    = vol_a[0];
    assign vol_r    = vol_a[1];

    always_comb begin
        latch     = req_vld && !st.busy;
        act       = st.busy && smp_vld;
        imm_mode  = zc_off || (fs_imm && over_fs);
        for (int c = 0; c < NUM_CH; c++) begin
            cause[c] = act && st.pend[c] ? pick_cause(imm_mode, tmo_exp, zc[c]) : UPD_NONE;
            fire[c]  = (cause[c] != UPD_NONE);
        end
        pend_left = st.pend & ~fire;
    end

    zcg_tmo_cnt u_tmo (
        .clk     (clk),
        .rst     (rst),
        .start   (latch),
        .busy    (st.busy),
        .smp_vld (smp_vld),
        .sel     (tmo_sel),
        .expire  (tmo_exp)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        zcg_zc_det #(.SAMPLE_W(SAMPLE_W)) u_zc (
            .clk     (clk),
            .rst     (rst),
            .smp_vld (smp_vld),
            .smp     (smp_a[c]),
            .zc      (zc[c])
        );
        zcg_chan_vol #(.VOL_W(VOL_W), .STEP_W(STEP_W), .VOL_INIT(VOL_INIT)) u_vol (
            .clk  (clk),
            .rst  (rst),
            .upd  (fire[c]),
            .imm  (imm_mode),
            .up   (st.up),
            .step (step_q),
            .vol  (vol_a[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            step_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= act && (pend_left == '0);
            if (latch) begin
                st.busy <= 1'b1;
                st.pend <= '1;
                st.up   <= req_up;
                step_q  <= req_step;
            end else if (act) begin
                st.pend <= pend_left;
                if (pend_left == '0) st.busy <= 1'b0;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R8
    AST_EXPIRE_ENDS: assert property (@(posedge clk) disable iff (rst)
        tmo_exp |=> !st.busy) else $error("timeout left channel pending"); // R2
    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        latch |=> ($stable(vol_l) && $stable(vol_r) && !done)) else $error("latch moved gain"); // R9
    AST_PEND_BUSY: assert property (@(posedge clk) disable iff (rst)
        st.busy == (st.pend != '0)) else $error("pending without busy"); // R9
endmodule

// File: tb/zcg_gain_updater_bench.sv
module zcg_gain_updater_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic signed [15:0] smp_l = '0, smp_r = '0;
    logic req_vld = 1'b0, req_up = 1'b0;
    logic [3:0] req_step = '0;
    logic [1:0] tmo_sel = '0;
    logic zc_off = 1'b0, fs_imm = 1'b0, over_fs = 1'b0;
    logic [7:0] vol_l, vol_r;
    logic done;

    int total = 0, bad = 0;
    string tag = "R1";

    int m_vol [2];
    bit m_busy, m_up, m_done;
    bit [1:0] m_pend;
    int m_step, m_cnt;
    bit m_prevneg [2];

    always #10 clk = ~clk;

    zcg_gain_updater u_zcg_gain_updater (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
        .req_vld(req_vld), .req_up(req_up), .req_step(req_step), .tmo_sel(tmo_sel),
        .zc_off(zc_off), .fs_imm(fs_imm), .over_fs(over_fs),
        .vol_l(vol_l), .vol_r(vol_r), .done(done)
    );

    function automatic int sat_move(int v, bit up, int amt);
        int n;
        n = up ? v + amt : v - amt;
        if (n < 0) n = 0;
        if (n > 255) n = 255;
        return n;
    endfunction

    task automatic chk(string what, int act_v, int exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act_v, exp_v);
        end
    endtask

    task automatic cyc(bit sv, int l, int r, bit rq, bit up, int stp);
        logic signed [15:0] cs [2];
        bit act, imm, ex, zc;
        bit [1:0] fire;
        int cn;
        smp_vld = sv; smp_l = 16'(l); smp_r = 16'(r);
        req_vld = rq; req_up = up; req_step = 4'(stp);
        cs[0] = 16'(l); cs[1] = 16'(r);
        act = m_busy && sv;
        imm = zc_off || (fs_imm && over_fs);
        cn  = m_cnt + 1;
        ex  = act && (cn >= (128 << tmo_sel));
        fire = '0;
        for (int c = 0; c < 2; c++) begin
            zc = (cs[c][15] != m_prevneg[c]) || (cs[c] == 0);
            fire[c] = act && m_pend[c] && (imm || ex || zc);
            if (fire[c]) m_vol[c] = sat_move(m_vol[c], m_up, imm ? 1 : m_step);
            if (sv) m_prevneg[c] = cs[c][15];
        end
        m_done = act && ((m_pend & ~fire) == 0);
        if (!m_busy && rq) begin
            m_busy = 1; m_pend = 2'b11; m_up = up; m_step = stp; m_cnt = 0;
        end else if (act) begin
            m_pend = m_pend & ~fire; m_cnt = cn;
            if (m_pend == 0) m_busy = 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk("vol_l", vol_l, m_vol[0]);
        chk("vol_r", vol_r, m_vol[1]);
        chk("done", done, m_done);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    // one request, then n positive samples so only the timeout can fire
    task automatic tmo_run(int sel, bit up, int stp, bit cross_last_l);
        int n;
        tmo_sel = 2'(sel);
        n = 128 << sel;
        cyc(1, 900, 900, 0, 0, 0);
        cyc(0, 0, 0, 1, up, stp);
        for (int i = 1; i <= n; i++) begin
            if (i == n - 1) chk("pre-expiry vol_l", vol_l, m_vol[0]);
            cyc(1, (cross_last_l && i == n) ? -700 : 900, 900, 0, 0, 0);
        end
        idle(2);
    endtask

    initial begin
        int v0;
        void'($urandom(32'd1357));
        m_vol[0] = 128; m_vol[1] = 128;
        m_busy = 0; m_up = 0; m_done = 0; m_pend = 0; m_step = 0; m_cnt = 0;
        m_prevneg[0] = 0; m_prevneg[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        chk("reset vol_l", vol_l, 128);
        chk("reset vol_r", vol_r, 128);
        chk("reset done", done, 0);
        idle(2);

        // R2: every timeout code, both directions, with a crossing on the expiry strobe
        tag = "R2";
        tmo_run(0, 0, 3, 1);
        chk("collision single step", vol_l, 125);
        tmo_run(1, 1, 2, 0);
        tmo_run(2, 0, 5, 0);
        tmo_run(3, 1, 4, 0);
        tmo_sel = 2'd0;

        // R3: left crosses at strobe 3, right at strobe 6, zero sample on right
        tag = "R3";
        cyc(1, 500, 500, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 2);
        cyc(1, 400, 300, 0, 0, 0);
        cyc(1, 300, 200, 0, 0, 0);
        cyc(1, -10, 100, 0, 0, 0);
        chk("left moved alone", vol_r, vol_l + 2);
        cyc(1, -20, 50, 0, 0, 0);
        cyc(1, -30, 20, 0, 0, 0);
        cyc(1, -40, 0, 0, 0, 0);
        idle(2);

        // R4: detection off forces one code regardless of step
        tag = "R4";
        zc_off = 1;
        v0 = vol_l;
        cyc(1, 500, 500, 1, 0, 9);
        cyc(1, 600, 600, 0, 0, 0);
        chk("one step down", vol_l, v0 - 1);
        zc_off = 0;
        idle(2);

        // R5: full-scale immediate, then same flag without over-full-scale
        tag = "R5";
        fs_imm = 1; over_fs = 1;
        v0 = vol_r;
        cyc(0, 0, 0, 1, 1, 7);
        cyc(1, 600, 600, 0, 0, 0);
        chk("one step up", vol_r, v0 + 1);
        over_fs = 0;
        cyc(0, 0, 0, 1, 1, 7);
        cyc(1, 700, 700, 0, 0, 0);
        cyc(1, -700, -700, 0, 0, 0);
        chk("zc rule applies", vol_r, v0 + 8);
        fs_imm = 0;
        idle(2);

        // R6: step of zero still completes
        tag = "R6";
        cyc(0, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        idle(2);

        // R7: saturate at both ends
        tag = "R7";
        for (int k = 0; k < 20; k++) begin
            cyc(0, 0, 0, 1, 0, 15);
            cyc(1, 0, 0, 0, 0, 0);
        end
        chk("floor", vol_l, 0);
        for (int k = 0; k < 20; k++) begin
            cyc(0, 0, 0, 1, 1, 15);
            cyc(1, 0, 0, 0, 0, 0);
        end
        chk("ceiling", vol_r, 255);

        // R9: request with strobe in the same cycle; request while busy
        tag = "R9";
        cyc(1, 100, 100, 0, 0, 0);
        cyc(1, -100, -100, 1, 0, 4);
        cyc(1, -200, -200, 1, 0, 9);
        cyc(1, -300, 300, 0, 0, 0);
        cyc(1, 300, 300, 0, 0, 0);
        chk("busy request ignored", vol_l, 251);
        idle(2);

        // R8 and R6: random mix
        tag = "R8";
        for (int i = 0; i < 4000; i++) begin
            zc_off  = ($urandom_range(0, 19) == 0);
            fs_imm  = $urandom_range(0, 1);
            over_fs = ($urandom_range(0, 3) == 0);
            cyc($urandom_range(0, 1), int'($urandom_range(0, 600)) - 300,
                int'($urandom_range(0, 600)) - 300, ($urandom_range(0, 7) == 0),
                $urandom_range(0, 1), $urandom_range(0, 15));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule